// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This block gives a host, which only sees a flat map of 16-bit switch registers, a way to reach the registers of internal PHYs. The host loads a target location into an address register and an optional high prefix register. For a write it also loads a data register. It then fires an operation by writing the control register. While the operation runs, the bridge drives a level request on an internal PHY port and waits for a one-cycle acknowledge. The host polls the status register until it reads zero, and after a read it collects the 16-bit result from the read-data register.

The host must treat a read as fragile. Once a read has been issued, touching any register other than status cancels it, with no error indication, and the read-data register keeps the result of the last read that finished. Writes are not fragile in this way. A PHY that never acknowledges is abandoned after a fixed number of cycles, so status always returns to zero.

Top module: `phy_reg_bridge`

## Requirements
- R1: After reset, status reads 0, the read-data register reads 0 and `phyReq` is low.
- R2: The control register is at 0x1F00. Bit 0 is the command bit and bit 1 selects the direction (0 = read, 1 = write). Control reads back as 0. Status at 0x1F01 returns busy in bit 0. It reads 1 from the cycle after an accepted command until the operation ends. Every host read is answered with `hostRvalid` and `hostRdata` one cycle after the request.
- R3: While a read is pending without an acknowledge, a host read or write to any address other than 0x1F01 cancels it. Undecoded addresses count. `phyReq` drops in the next cycle and status reads 0.
- R4: The read-data register at 0x1F04 holds the data of the most recent read that was acknowledged. A cancelled or timed-out read leaves it unchanged.
- R5: A write operation keeps `phyReq` asserted through host accesses to any register until it is acknowledged or times out.
- R6: PHY data is 16 bits wide. A completed read returns exactly the `phyRdata` word presented with the acknowledge.
- R7: The address register at 0x1F02 is laid out as follows: bits [4:0] hold target bits [5:1], bits [8:5] hold target bits [9:6], and bits [13:9] hold the PHY number. The prefix register at 0x1F10, bits [5:0], holds target bits [15:10]. The bridge drives `phyAddr` = {prefix, bits 9:6, bits 5:1, 1'b0} and `phySel` = PHY number. Write data is taken from 0x1F03.
- R8: `phyAddr`, `phySel`, `phyWdata` and `phyWe` are captured when a command is accepted and stay stable while `phyReq` is high, even if the host rewrites the source registers.
- R9: A command written while a write operation is busy is ignored. No second PHY request is issued and the read-data register is untouched.
- R10: `phyReq` stays high for at most TIMEOUT_CYC cycles. Without an acknowledge, status then returns to 0 and nothing is latched.
- R11: Host reads of undecoded addresses return 0.
- R12: If the acknowledge of a read arrives in the same cycle as a foreign host access, the read completes and its data is latched.
- R13: Reading status never cancels an operation. Reading it while idle returns 0 and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Host access strobe, one cycle per access |
| hostWe | input | 1 | 1 = host write, 0 = host read |
| hostAddr | input | 16 | Host register address |
| hostWdata | input | DATA_W | Host write data |
| hostRvalid | output | 1 | Read response valid, one cycle after a read request |
| hostRdata | output | DATA_W | Read response data |
| phyReq | output | 1 | PHY request, held until acknowledge, cancel or timeout |
| phyWe | output | 1 | PHY operation direction, 1 = write |
| phySel | output | SEL_W | Target PHY number |
| phyAddr | output | PFX_W+MID_W+LOW_W+1 | Target register address inside the PHY |
| phyWdata | output | DATA_W | PHY write data |
| phyAck | input | 1 | PHY acknowledge, one cycle |
| phyRdata | input | DATA_W | PHY read data, valid with `phyAck` |

## Verification
Two functions can land on the same clock edge: a read's acknowledge and a host access that would cancel that read. The bench provokes this by setting the responder's acknowledge delay to d, issuing a read, and placing a foreign host access k cycles after the command. It sweeps k and d, both directed and at random, so k falls before, on, and after d. The outcome is judged at the ports only: after the status poll, the read-data register must hold the new PHY word exactly when k >= d, and the previous word otherwise.

// File: rtl/phy_bridge_pkg.sv
package phy_bridge_pkg;

  localparam int HOST_AW = 16;

  // decoded register indices
  localparam int IDX_CTRL = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_ADDR = 2;
  localparam int IDX_WDAT = 3;
  localparam int IDX_RDAT = 4;
  localparam int IDX_PFX  = 5;
  localparam int N_REGS   = 6;

  localparam logic [HOST_AW-1:0] OFS_CTRL = 16'h1F00;
  localparam logic [HOST_AW-1:0] OFS_STAT = 16'h1F01;
  localparam logic [HOST_AW-1:0] OFS_ADDR = 16'h1F02;
  localparam logic [HOST_AW-1:0] OFS_WDAT = 16'h1F03;
  localparam logic [HOST_AW-1:0] OFS_RDAT = 16'h1F04;
  localparam logic [HOST_AW-1:0] OFS_PFX  = 16'h1F10;

  localparam logic [HOST_AW-1:0] OFS_LIST [N_REGS] =
    '{OFS_CTRL, OFS_STAT, OFS_ADDR, OFS_WDAT, OFS_RDAT, OFS_PFX};

  // control -> datapath strobes
  typedef struct packed {
    logic launch;   // capture operation fields
    logic opWrite;  // direction captured at launch
    logic latchRd;  // store PHY read data
  } strobe_t;

  typedef enum logic {ST_IDLE, ST_WAIT} state_t;

endpackage

// File: rtl/phy_bridge_dp.sv
module phy_bridge_dp
  import phy_bridge_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 5,
  parameter int PFX_W  = 6,
  parameter int MID_W  = 4,
  parameter int LOW_W  = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     hostReq,
  input  logic                     hostWe,
  input  logic [HOST_AW-1:0]       hostAddr,
  input  logic [DATA_W-1:0]        hostWdata,
  input  logic                     busy,
  input  strobe_t                  strb,
  input  logic [DATA_W-1:0]        phyRdata,
  output logic                     hostRvalid,
  output logic [DATA_W-1:0]        hostRdata,
  output logic                     cmdGo,
  output logic                     cmdIsWrite,
  output logic                     foreignHit,
  output logic                     phyWe,
  output logic [SEL_W-1:0]         phySel,
  output logic [PFX_W+MID_W+LOW_W:0] phyAddr,
  output logic [DATA_W-1:0]        phyWdata
);

  localparam int AREG_W = SEL_W + MID_W + LOW_W;
  localparam int OCP_W  = PFX_W + MID_W + LOW_W + 1;

  logic [N_REGS-1:0] hitVec;
  logic [AREG_W-1:0] addrQ;
  logic [PFX_W-1:0]  pfxQ;
  logic [DATA_W-1:0] wdatQ;
  logic [DATA_W-1:0] rdatQ;
  logic [DATA_W-1:0] rdNext;
  logic [OCP_W-1:0]  targetAddr;
  logic              hostWr;

  for (genvar gi = 0; gi < N_REGS; gi++) begin : g_dec
    assign hitVec[gi] = (hostAddr == OFS_LIST[gi]);
  end

  assign hostWr     = hostReq & hostWe;
  assign cmdGo      = hostWr & hitVec[IDX_CTRL] & hostWdata[0];
  assign cmdIsWrite = hostWdata[1];
  assign foreignHit = hostReq & ~hitVec[IDX_STAT];

  assign targetAddr = {pfxQ, addrQ[MID_W+LOW_W-1:LOW_W], addrQ[LOW_W-1:0], 1'b0};

  // host-visible registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      pfxQ  <= '0;
      wdatQ <= '0;
    end else if (hostWr) begin
      if (hitVec[IDX_ADDR]) addrQ <= hostWdata[AREG_W-1:0];
      if (hitVec[IDX_PFX])  pfxQ  <= hostWdata[PFX_W-1:0];
      if (hitVec[IDX_WDAT]) wdatQ <= hostWdata;
    end
  end

  // result holding register
  always_ff @(posedge clk) begin
    if (!rstN)             rdatQ <= '0;
    else if (strb.latchRd) rdatQ <= phyRdata;
  end

  // operation fields, frozen for the whole request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phyWe    <= 1'b0;
      phySel   <= '0;
      phyAddr  <= '0;
      phyWdata <= '0;
    end else if (strb.launch) begin
      phyWe    <= strb.opWrite;
      phySel   <= addrQ[AREG_W-1:MID_W+LOW_W];
      phyAddr  <= targetAddr;
      phyWdata <= wdatQ;
    end
  end

  always_comb begin
    rdNext = '0;
    if (hitVec[IDX_STAT])      rdNext = DATA_W'(busy);
    else if (hitVec[IDX_ADDR]) rdNext = DATA_W'(addrQ);
    else if (hitVec[IDX_WDAT]) rdNext = wdatQ;
    else if (hitVec[IDX_RDAT]) rdNext = rdatQ;
    else if (hitVec[IDX_PFX])  rdNext = DATA_W'(pfxQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRvalid <= 1'b0;
      hostRdata  <= '0;
    end else begin
      hostRvalid <= hostReq & ~hostWe;
      hostRdata  <= (hostReq & ~hostWe) ? rdNext : '0;
    end
  end

endmodule

// File: rtl/phy_bridge_ctrl.sv
module phy_bridge_ctrl
  import phy_bridge_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdGo,
  input  logic    cmdIsWrite,
  input  logic    foreignHit,
  input  logic    phyAck,
  output logic    busy,
  output logic    phyReq,
  output strobe_t strb
);

  localparam int TW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);

  state_t        stateQ;
  logic [TW-1:0] timerQ;
  logic          opWriteQ;
  logic          ackTake;
  logic          abortHit;
  logic          expire;

  assign busy     = (stateQ == ST_WAIT);
  assign phyReq   = busy;
  assign ackTake  = busy & phyAck;
  // the acknowledge wins over a same-cycle foreign access
  assign abortHit = busy & ~phyAck & ~opWriteQ & foreignHit;
  assign expire   = busy & ~phyAck & (timerQ == T_LAST);

  always_comb begin
    strb         = '0;
    strb.launch  = ~busy & cmdGo;
    strb.opWrite = cmdIsWrite;
    strb.latchRd = ackTake & ~opWriteQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      timerQ   <= '0;
      opWriteQ <= 1'b0;
    end else begin
      unique case (stateQ)
        ST_IDLE: if (cmdGo) begin
          stateQ   <= ST_WAIT;
          timerQ   <= '0;
          opWriteQ <= cmdIsWrite;
        end
        ST_WAIT: begin
          if (ackTake || abortHit || expire) stateQ <= ST_IDLE;
          else                               timerQ <= timerQ + 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phy_reg_bridge.sv
module phy_reg_bridge
  import phy_bridge_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SEL_W       = 5,
  parameter int PFX_W       = 6,
  parameter int MID_W       = 4,
  parameter int LOW_W       = 5,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       hostReq,
  input  logic                       hostWe,
  input  logic [15:0]                hostAddr,
  input  logic [DATA_W-1:0]          hostWdata,
  output logic                       hostRvalid,
  output logic [DATA_W-1:0]          hostRdata,
  output logic                       phyReq,
  output logic                       phyWe,
  output logic [SEL_W-1:0]           phySel,
  output logic [PFX_W+MID_W+LOW_W:0] phyAddr,
  output logic [DATA_W-1:0]          phyWdata,
  input  logic                       phyAck,
  input  logic [DATA_W-1:0]          phyRdata
);

  strobe_t strb;
  logic    busy;
  logic    cmdGo;
  logic    cmdIsWrite;
  logic    foreignHit;

  phy_bridge_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdGo      (cmdGo),
    .cmdIsWrite (cmdIsWrite),
    .foreignHit (foreignHit),
    .phyAck     (phyAck),
    .busy       (busy),
    .phyReq     (phyReq),
    .strb       (strb)
  );

  phy_bridge_dp #(
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W),
    .PFX_W  (PFX_W),
    .MID_W  (MID_W),
    .LOW_W  (LOW_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .hostReq    (hostReq),
    .hostWe     (hostWe),
    .hostAddr   (hostAddr),
    .hostWdata  (hostWdata),
    .busy       (busy),
    .strb       (strb),
    .phyRdata   (phyRdata),
    .hostRvalid (hostRvalid),
    .hostRdata  (hostRdata),
    .cmdGo      (cmdGo),
    .cmdIsWrite (cmdIsWrite),
    .foreignHit (foreignHit),
    .phyWe      (phyWe),
    .phySel     (phySel),
    .phyAddr    (phyAddr),
    .phyWdata   (phyWdata)
  );

endmodule

// File: rtl/phy_bridge_chk.sv
module phy_bridge_chk
  import phy_bridge_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SEL_W       = 5,
  parameter int AW          = 16,
  parameter int TIMEOUT_CYC = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostReq,
  input logic              hostWe,
  input logic [15:0]       hostAddr,
  input logic              hostRvalid,
  input logic [DATA_W-1:0] hostRdata,
  input logic              phyReq,
  input logic              phyWe,
  input logic [SEL_W-1:0]  phySel,
  input logic [AW-1:0]     phyAddr,
  input logic [DATA_W-1:0] phyWdata,
  input logic              phyAck,
  input logic [DATA_W-1:0] phyRdata
);

  int unsigned       reqCnt;
  logic [DATA_W-1:0] shadowRd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqCnt   <= 0;
      shadowRd <= '0;
    end else begin
      reqCnt <= phyReq ? reqCnt + 1 : 0;
      if (phyReq && phyAck && !phyWe) shadowRd <= phyRdata;
    end
  end

  a_r2_read_response: assert property (@(posedge clk) disable iff (!rstN)
    hostRvalid |-> $past(hostReq && !hostWe));

  a_r3_foreign_cancels_read: assert property (@(posedge clk) disable iff (!rstN)
    (phyReq && !phyWe && !phyAck && hostReq && hostAddr != OFS_STAT) |=> !phyReq);

  a_r4_rdata_last_completed: assert property (@(posedge clk) disable iff (!rstN)
    (hostRvalid && $past(hostAddr == OFS_RDAT)) |-> hostRdata == $past(shadowRd));

  a_r5_write_survives: assert property (@(posedge clk) disable iff (!rstN)
    (phyReq && phyWe && !phyAck && reqCnt < TIMEOUT_CYC - 1) |=> phyReq);

  a_r8_fields_stable: assert property (@(posedge clk) disable iff (!rstN)
    (phyReq && $past(phyReq)) |-> ($stable(phyAddr) && $stable(phySel) &&
                                   $stable(phyWdata) && $stable(phyWe)));

  a_r10_timeout_bound: assert property (@(posedge clk) disable iff (!rstN)
    reqCnt <= TIMEOUT_CYC);

  a_r6_ack_ends_request: assert property (@(posedge clk) disable iff (!rstN)
    (phyReq && phyAck) |=> !phyReq);

endmodule

bind phy_reg_bridge phy_bridge_chk #(
  .DATA_W      (DATA_W),
  .SEL_W       (SEL_W),
  .AW          (PFX_W + MID_W + LOW_W + 1),
  .TIMEOUT_CYC (TIMEOUT_CYC)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .hostReq    (hostReq),
  .hostWe     (hostWe),
  .hostAddr   (hostAddr),
  .hostRvalid (hostRvalid),
  .hostRdata  (hostRdata),
  .phyReq     (phyReq),
  .phyWe      (phyWe),
  .phySel     (phySel),
  .phyAddr    (phyAddr),
  .phyWdata   (phyWdata),
  .phyAck     (phyAck),
  .phyRdata   (phyRdata)
);

// File: tb/sim_phy_reg_bridge.sv
module sim_phy_reg_bridge;
  import phy_bridge_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int TOUT = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0;
  logic        hostWe = 1'b0;
  logic [15:0] hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic        hostRvalid;
  logic [15:0] hostRdata;
  logic        phyReq;
  logic        phyWe;
  logic [4:0]  phySel;
  logic [15:0] phyAddr;
  logic [15:0] phyWdata;
  logic        phyAck = 1'b0;
  logic [15:0] phyRdata = '0;

  int nChecks = 0;
  int nErr = 0;
  int ackDelay = 4;
  int respCnt = 0;
  int reqCount = 0;
  int wrCount = 0;
  logic [15:0] lastWrData = '0;
  logic [15:0] lastAckAddr = '0;
  logic [4:0]  lastAckSel = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_reg_bridge #(.TIMEOUT_CYC(TOUT)) u0 (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRvalid(hostRvalid),
    .hostRdata(hostRdata), .phyReq(phyReq), .phyWe(phyWe), .phySel(phySel),
    .phyAddr(phyAddr), .phyWdata(phyWdata), .phyAck(phyAck), .phyRdata(phyRdata)
  );

  function automatic logic [15:0] phyModel(input logic [15:0] a, input logic [4:0] s);
    return a ^ {s, 11'h0} ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] addrWord(input logic [4:0] phy, input logic [15:0] t);
    return {2'b00, phy, t[9:6], t[5:1]};
  endfunction

  // PHY responder: acknowledges after ackDelay cycles of request
  always @(negedge clk) begin
    if (phyReq) begin
      respCnt = respCnt + 1;
      if (respCnt == 1) reqCount = reqCount + 1;
      phyAck   = (respCnt == ackDelay);
      phyRdata = phyModel(phyAddr, phySel);
      if (phyAck) begin
        lastAckAddr = phyAddr;
        lastAckSel  = phySel;
        if (phyWe) begin
          wrCount = wrCount + 1;
          lastWrData = phyWdata;
        end
      end
    end else begin
      respCnt = 0;
      phyAck  = 1'b0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic hostAcc(input logic we, input logic [15:0] a, input logic [15:0] d,
                         output logic [15:0] rd);
    hostReq = 1'b1; hostWe = we; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostReq = 1'b0; hostWe = 1'b0;
    rd = hostRdata;
    if (!we) check("R2 rvalid", {31'b0, hostRvalid}, 32'd1);
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    logic [15:0] dummy;
    hostAcc(1'b1, a, d, dummy);
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] v);
    hostAcc(1'b0, a, 16'h0, v);
  endtask

  task automatic pollIdle(output int polls);
    logic [15:0] s;
    polls = 0;
    for (int i = 0; i < 300; i++) begin
      rd(OFS_STAT, s);
      polls++;
      if (s == 16'h0) break;
    end
  endtask

  task automatic setTarget(input logic [4:0] phy, input logic [15:0] t);
    wr(OFS_PFX, {10'h0, t[15:10]});
    wr(OFS_ADDR, addrWord(phy, t));
  endtask

  logic [15:0] expRd = '0;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin : stim
    logic [15:0] v;
    int polls;
    int seedDummy;
    seedDummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 phyReq", {31'b0, phyReq}, 0);
    rd(OFS_STAT, v); check("R1 status", v, 0);
    rd(OFS_RDAT, v); check("R1 rdata", v, 0);

    // R11 undecoded read, R13 idle status read starts nothing
    rd(16'h0123, v); check("R11 undecoded", v, 0);
    rd(OFS_STAT, v); check("R13 idle status", v, 0);
    check("R13 no request", reqCount, 0);
    rd(OFS_CTRL, v); check("R2 ctrl reads zero", v, 0);

    // R2/R6/R7/R13 basic read with status polling in flight
    ackDelay = 6;
    setTarget(5'd3, 16'hB6D4);
    wr(OFS_CTRL, 16'h0001);
    rd(OFS_STAT, v); check("R2 busy", v, 1);
    pollIdle(polls);
    check("R13 status poll no abort", {31'b0, polls > 1}, 1);
    check("R7 phyAddr", lastAckAddr, 16'hB6D4);
    check("R7 phySel", lastAckSel, 5'd3);
    expRd = phyModel(16'hB6D4, 5'd3);
    rd(OFS_RDAT, v); check("R6 read data", v, expRd);
    rd(OFS_ADDR, v); check("R7 addr readback", v, addrWord(5'd3, 16'hB6D4));

    // R3/R4 abort by undecoded read
    ackDelay = 6;
    setTarget(5'd7, 16'h1234);
    wr(OFS_CTRL, 16'h0001);
    rd(16'h0777, v);
    check("R3 phyReq dropped (undecoded)", {31'b0, phyReq}, 0);
    rd(OFS_STAT, v); check("R3 status idle", v, 0);
    rd(OFS_RDAT, v); check("R4 rdata kept (undecoded)", v, expRd);

    // R3/R4 abort by write to write-data register
    wr(OFS_CTRL, 16'h0001);
    wr(OFS_WDAT, 16'hCAFE);
    check("R3 phyReq dropped (wdata write)", {31'b0, phyReq}, 0);
    pollIdle(polls);
    rd(OFS_RDAT, v); check("R4 rdata kept (wdata write)", v, expRd);

    // R5/R8/R9 write survives foreign traffic, fields frozen, command ignored
    ackDelay = 8;
    setTarget(5'd9, 16'h4C8A);
    wr(OFS_WDAT, 16'h9E21);
    begin
      int rc0, wc0;
      rc0 = reqCount; wc0 = wrCount;
      wr(OFS_CTRL, 16'h0003);
      rd(OFS_ADDR, v);
      wr(OFS_PFX, 16'h003F);
      wr(OFS_WDAT, 16'h0000);
      wr(OFS_CTRL, 16'h0001);
      check("R5 write still pending", {31'b0, phyReq}, 1);
      pollIdle(polls);
      check("R5 write done", wrCount, wc0 + 1);
      check("R9 single request", reqCount, rc0 + 1);
      check("R8 write data frozen", lastWrData, 16'h9E21);
      check("R8 addr frozen", lastAckAddr, 16'h4C8A);
      rd(OFS_RDAT, v); check("R9 rdata untouched", v, expRd);
    end

    // R10 timeout
    ackDelay = 100000;
    setTarget(5'd1, 16'h0F0E);
    wr(OFS_CTRL, 16'h0001);
    repeat (TOUT/2) @(negedge clk);
    rd(OFS_STAT, v); check("R10 busy before timeout", v, 1);
    repeat (TOUT) @(negedge clk);
    check("R10 request released", {31'b0, phyReq}, 0);
    rd(OFS_STAT, v); check("R10 status after timeout", v, 0);
    rd(OFS_RDAT, v); check("R10 nothing latched", v, expRd);

    // R12 directed collision: foreign access on the ack cycle
    ackDelay = 4;
    setTarget(5'd2, 16'hE002);
    wr(OFS_CTRL, 16'h0001);
    repeat (3) @(negedge clk);
    rd(OFS_ADDR, v);
    pollIdle(polls);
    expRd = phyModel(16'hE002, 5'd2);
    rd(OFS_RDAT, v); check("R12 collision completes", v, expRd);

    // R3/R4/R12 random sweep of access offset k against ack delay d
    for (int it = 0; it < 80; it++) begin
      int k, d;
      logic [15:0] t;
      logic [4:0]  p;
      logic        undec;
      k = 1 + int'($urandom_range(7));
      d = 1 + int'($urandom_range(7));
      t = 16'($urandom) & 16'hFFFE;
      p = 5'($urandom);
      undec = 1'($urandom);
      ackDelay = d;
      setTarget(p, t);
      wr(OFS_CTRL, 16'h0001);
      if (k > 1) repeat (k - 1) @(negedge clk);
      if (undec) begin
        rd(16'h2000, v); check("R11 undecoded in sweep", v, 0);
      end else begin
        rd(OFS_ADDR, v); check("R7 addr in sweep", v, addrWord(p, t));
      end
      if (k < d) check("R3 cancelled in sweep", {31'b0, phyReq}, 0);
      pollIdle(polls);
      if (k >= d) expRd = phyModel(t, p);
      rd(OFS_RDAT, v);
      check(k >= d ? "R12 completed in sweep" : "R4 kept in sweep", v, expRd);
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule